// File: doc/BRIEF.md
# Static-Prediction Instruction Fetch Unit

This block is the fetch stage of an in-order, non-speculative 32-bit scalar front end. It keeps a fetch program counter, sends word-aligned addresses to an instruction memory, and hands each 32-bit instruction on to decode. The stored program counter and a predicted-taken flag travel with each instruction. Compressed encodings do not exist here, so every address advances by four.

Every response is predecoded as it arrives. A conditional branch with a negative offset (backward) is guessed taken. A conditional branch with a positive or zero offset is guessed not taken. An unconditional jump-and-link always redirects fetch. A register-indirect jump is left to execute and fetch carries on past it. On a taken guess, the request already in flight down the sequential path is discarded as it returns. The execute stage owns the real outcome. When that outcome differs from the guess, execute pulses a fix strobe with the correct address. Fetch then empties its buffer, discards every outstanding response, and restarts at that address.

The decode side is valid/ready. While valid is high and ready is low, the offered instruction, its address and its flag stay unchanged, and nothing is lost. The memory request channel is also valid/ready. A request waits on a low grant with its address unchanged, except when a redirect replaces it. The memory must answer in order, one response per granted request, and the response channel has no back-pressure. Fetch never holds more requests and buffered instructions than its buffer can absorb.

Top module: `ifu_static`

## Requirements
- R1: While reset is asserted, no instruction is offered to decode and the request address equals the BOOT_ADDR parameter.
- R2: Without redirects, instructions reach decode in ascending address order, four bytes apart, and every request address has bits [1:0] equal to zero.
- R3: A conditional branch (opcode bits [6:0] = 1100011) with instruction bit 31 set is offered with the taken flag high, and the next instruction offered is the one at its address plus the sign-extended B-type offset.
- R4: A conditional branch with instruction bit 31 clear (forward or zero offset) is offered with the taken flag low, and the next instruction offered is the one at its address plus four.
- R5: A jump-and-link (opcode 1101111) is offered with the taken flag high and is followed by the instruction at its J-type target. A register-indirect jump (opcode 1100111) is offered with the taken flag low.
- R6: On a taken guess, the sequential instruction already requested never reaches decode. With decode ready and memory granting, the target is offered exactly two cycles after the redirecting instruction was offered, leaving one empty cycle.
- R7: A fix strobe discards every buffered and in-flight instruction. In the next cycle the request address equals the fix address and decode sees nothing. With decode ready and memory granting, the instruction at the fix address is offered in the third cycle after the fix cycle.
- R8: While decode holds ready low, the offered instruction, address and flag stay stable. No instruction is lost or duplicated.
- R9: A request that is not granted keeps its address in the next cycle, unless a redirect occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_req_valid | output | 1 | Fetch request present |
| imem_req_ready | input | 1 | Memory accepts the request |
| imem_req_addr | output | 32 | Word-aligned fetch address |
| imem_rsp_valid | input | 1 | Response data present, in request order |
| imem_rsp_data | input | 32 | Fetched instruction word |
| dec_valid | output | 1 | Instruction offered to decode |
| dec_ready | input | 1 | Decode accepts the instruction |
| dec_pc | output | 32 | Address of the offered instruction |
| dec_instr | output | 32 | Offered instruction word |
| dec_pred_taken | output | 1 | Static guess made at fetch |
| ex_fix_valid | input | 1 | Execute found a wrong guess; restart |
| ex_fix_pc | input | 32 | Correct address to restart from |

## Verification
The bench runs a small program that contains each control-flow kind. A forward branch that execute overrules separates the fix path from plain sequential flow. A jump-and-link and a backward loop branch show whether the taken guess discards the sequential word and keeps the one-cycle gap. A zero-offset branch tells a sign test apart from a test for a nonzero offset. A register-indirect jump shows that only execute redirects it. The same loop then runs with decode and memory stalling in interleaved patterns, which shows whether back-pressure on either side drops, repeats or reorders instructions.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  localparam int XLEN = 32;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  typedef struct packed {
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] instr;
    logic            taken;
  } fetch_pkt_t;
endpackage

// File: rtl/ifu_predecode.sv
module ifu_predecode
  import ifu_pkg::*;
(
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] instr,
  output logic            taken,
  output logic [XLEN-1:0] target
);
  logic [XLEN-1:0] b_off;
  logic [XLEN-1:0] j_off;

  always_comb begin
    b_off = {{(XLEN-12){instr[31]}}, instr[7], instr[30:25], instr[11:8], 1'b0};
    j_off = {{(XLEN-20){instr[31]}}, instr[19:12], instr[20], instr[30:21], 1'b0};
    taken  = 1'b0;
    target = pc + XLEN'(4);
    unique case (instr[6:0])
      OPC_BRANCH: begin
        taken  = instr[31];
        target = pc + b_off;
      end
      OPC_JAL: begin
        taken  = 1'b1;
        target = pc + j_off;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ifu_ibuf.sv
module ifu_ibuf #(
  parameter int W     = 65,
  parameter int DEPTH = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          nonempty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= din;
  end

  assign dout     = slots[rd_ptr];
  assign nonempty = (count != '0);
endmodule

// File: rtl/ifu_credit.sv
module ifu_credit #(
  parameter int DEPTH = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_fire,
  input  logic          rsp_fire,
  input  logic          redirect,
  output logic [CW-1:0] inflight,
  output logic [CW-1:0] drop
);
  logic [CW-1:0] inflight_n;

  always_comb begin
    inflight_n = inflight + CW'(req_fire) - CW'(rsp_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight <= '0;
      drop     <= '0;
    end else begin
      inflight <= inflight_n;
      if (redirect)
        drop <= inflight_n;
      else if (rsp_fire && drop != '0)
        drop <= drop - 1'b1;
    end
  end
endmodule

// File: rtl/ifu_static.sv
module ifu_static
  import ifu_pkg::*;
#(
  parameter logic [31:0] BOOT_ADDR  = 32'h0000_0100,
  parameter int          IBUF_DEPTH = 2,
  localparam int CW = $clog2(IBUF_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        imem_req_valid,
  input  logic        imem_req_ready,
  output logic [31:0] imem_req_addr,
  input  logic        imem_rsp_valid,
  input  logic [31:0] imem_rsp_data,
  output logic        dec_valid,
  input  logic        dec_ready,
  output logic [31:0] dec_pc,
  output logic [31:0] dec_instr,
  output logic        dec_pred_taken,
  input  logic        ex_fix_valid,
  input  logic [31:0] ex_fix_pc
);
  localparam int PKT_W = $bits(fetch_pkt_t);

  logic [31:0]   fetch_pc;
  logic [31:0]   rsp_pc;
  logic          pd_taken;
  logic [31:0]   pd_target;
  logic          rsp_live;
  logic          pred_redirect;
  logic          req_fire;
  logic          pop;
  logic [CW-1:0] buf_count;
  logic [CW-1:0] inflight;
  logic [CW-1:0] drop;
  logic [CW:0]   occupancy;
  fetch_pkt_t    pkt_in, pkt_out;
  logic [PKT_W-1:0] pkt_out_bits;

  ifu_predecode u_pd (
    .pc     (rsp_pc),
    .instr  (imem_rsp_data),
    .taken  (pd_taken),
    .target (pd_target)
  );

  assign rsp_live      = imem_rsp_valid && (drop == '0) && !ex_fix_valid;
  assign pred_redirect = rsp_live && pd_taken;
  assign pop           = dec_valid && dec_ready;

  always_comb begin
    occupancy = (CW+1)'(buf_count) + (CW+1)'(inflight) - (CW+1)'(pop);
  end

  assign imem_req_valid = (occupancy < (CW+1)'(IBUF_DEPTH));
  assign imem_req_addr  = fetch_pc;
  assign req_fire       = imem_req_valid && imem_req_ready;

  ifu_credit #(.DEPTH(IBUF_DEPTH)) u_credit (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (req_fire),
    .rsp_fire (imem_rsp_valid),
    .redirect (ex_fix_valid || pred_redirect),
    .inflight (inflight),
    .drop     (drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_pc <= BOOT_ADDR;
      rsp_pc   <= BOOT_ADDR;
    end else begin
      if (ex_fix_valid)       fetch_pc <= ex_fix_pc;
      else if (pred_redirect) fetch_pc <= pd_target;
      else if (req_fire)      fetch_pc <= fetch_pc + 32'd4;

      if (ex_fix_valid)       rsp_pc <= ex_fix_pc;
      else if (pred_redirect) rsp_pc <= pd_target;
      else if (rsp_live)      rsp_pc <= rsp_pc + 32'd4;
    end
  end

  always_comb begin
    pkt_in.pc    = rsp_pc;
    pkt_in.instr = imem_rsp_data;
    pkt_in.taken = pd_taken;
  end

  ifu_ibuf #(.W(PKT_W), .DEPTH(IBUF_DEPTH)) u_ibuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (ex_fix_valid),
    .push     (rsp_live),
    .din      (pkt_in),
    .pop      (pop),
    .dout     (pkt_out_bits),
    .nonempty (dec_valid),
    .count    (buf_count)
  );

  assign pkt_out        = fetch_pkt_t'(pkt_out_bits);
  assign dec_pc         = pkt_out.pc;
  assign dec_instr      = pkt_out.instr;
  assign dec_pred_taken = pkt_out.taken;
endmodule

// File: rtl/ifu_static_chk.sv
module ifu_static_chk
  import ifu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        imem_req_valid,
  input logic        imem_req_ready,
  input logic [31:0] imem_req_addr,
  input logic        dec_valid,
  input logic        dec_ready,
  input logic [31:0] dec_pc,
  input logic [6:0]  dec_op,
  input logic        dec_sign,
  input logic        dec_pred_taken,
  input logic        ex_fix_valid,
  input logic [31:0] ex_fix_pc,
  input logic        pred_redirect
);
  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req_valid |-> imem_req_addr[1:0] == 2'b00);

  assert_back_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_op == OPC_BRANCH && dec_sign) |-> dec_pred_taken);

  assert_fwd_not_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_op == OPC_BRANCH && !dec_sign) |-> !dec_pred_taken);

  assert_jal_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_op == OPC_JAL) |-> dec_pred_taken);

  assert_jalr_not_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_op == OPC_JALR) |-> !dec_pred_taken);

  assert_fix_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ex_fix_valid |=> imem_req_addr == $past(ex_fix_pc));

  assert_fix_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ex_fix_valid |=> !dec_valid);

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready && !ex_fix_valid) |=>
      (dec_valid && $stable(dec_pc) && $stable(dec_op) && $stable(dec_sign)
       && $stable(dec_pred_taken)));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_req_valid && !imem_req_ready && !ex_fix_valid && !pred_redirect) |=>
      $stable(imem_req_addr));
endmodule

bind ifu_static ifu_static_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .imem_req_valid (imem_req_valid),
  .imem_req_ready (imem_req_ready),
  .imem_req_addr  (imem_req_addr),
  .dec_valid      (dec_valid),
  .dec_ready      (dec_ready),
  .dec_pc         (dec_pc),
  .dec_op         (dec_instr[6:0]),
  .dec_sign       (dec_instr[31]),
  .dec_pred_taken (dec_pred_taken),
  .ex_fix_valid   (ex_fix_valid),
  .ex_fix_pc      (ex_fix_pc),
  .pred_redirect  (pred_redirect)
);

// File: tb/test_ifu_static.sv
module test_ifu_static;
  localparam logic [31:0] BOOT = 32'h0000_0100;
  localparam int TRACE_LEN = 40;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] instr;
    logic        taken;
    bit          fix;
    logic [31:0] fix_pc;
    int          kind;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic imem_req_valid, imem_req_ready;
  logic [31:0] imem_req_addr;
  logic imem_rsp_valid;
  logic [31:0] imem_rsp_data;
  logic dec_valid, dec_ready, dec_pred_taken;
  logic [31:0] dec_pc, dec_instr;
  logic ex_fix_valid;
  logic [31:0] ex_fix_pc;

  int checks = 0, errors = 0;
  exp_t exp_q[$];
  bit started = 0, phase2 = 0, pend_fix = 0, finished = 0;
  logic [31:0] pend_pc;

  always #10 clk = ~clk;

  ifu_static #(.BOOT_ADDR(BOOT)) i_ifu_static (
    .clk(clk), .rst_n(rst_n),
    .imem_req_valid(imem_req_valid), .imem_req_ready(imem_req_ready),
    .imem_req_addr(imem_req_addr),
    .imem_rsp_valid(imem_rsp_valid), .imem_rsp_data(imem_rsp_data),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_pc(dec_pc),
    .dec_instr(dec_instr), .dec_pred_taken(dec_pred_taken),
    .ex_fix_valid(ex_fix_valid), .ex_fix_pc(ex_fix_pc)
  );

  // kind: 0 plain, 1 conditional branch, 2 jump-and-link, 3 register jump
  function automatic int kind_of(logic [31:0] a);
    case (a)
      32'h108, 32'h128, 32'h200, 32'h20C, 32'h214: return 1;
      32'h114: return 2;
      32'h12C: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int off_of(logic [31:0] a);
    case (a)
      32'h108: return 12;
      32'h114: return 16;
      32'h128: return -8;
      32'h200: return 0;
      32'h20C: return 8;
      32'h214: return -20;
      default: return 4;
    endcase
  endfunction

  function automatic logic [31:0] enc_b(int off, bit ne);
    logic [12:0] b;
    b = off[12:0];
    return {b[12], b[10:5], 5'd2, 5'd1, ne ? 3'b001 : 3'b000, b[4:1], b[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] enc_j(int off);
    logic [20:0] j;
    j = off[20:0];
    return {j[20], j[10:1], j[11], j[19:12], 5'd1, 7'b1101111};
  endfunction

  function automatic logic [31:0] prog(logic [31:0] a);
    case (kind_of(a))
      1: return enc_b(off_of(a), a == 32'h128);
      2: return enc_j(off_of(a));
      3: return 32'h0000_8067;
      default: return 32'h0000_0013;
    endcase
  endfunction

  // memory: answers one cycle after each granted request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imem_rsp_valid <= 1'b0;
      imem_rsp_data  <= '0;
    end else begin
      imem_rsp_valid <= imem_req_valid && imem_req_ready;
      imem_rsp_data  <= prog(imem_req_addr);
    end
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // driver: builds the expected path, execute overrules chosen guesses
  task automatic build_trace();
    logic [31:0] pc;
    int visits = 0;
    pc = BOOT;
    for (int i = 0; i < TRACE_LEN; i++) begin
      exp_t e;
      int k;
      k = kind_of(pc);
      e.pc = pc; e.instr = prog(pc); e.kind = k; e.fix = 0; e.fix_pc = '0;
      e.taken = (k == 2) || (k == 1 && off_of(pc) < 0);
      if (pc == 32'h108) begin e.fix = 1; e.fix_pc = 32'h114; end
      if (pc == 32'h128) begin
        visits++;
        if (visits == 2) begin e.fix = 1; e.fix_pc = 32'h12C; end
      end
      if (pc == 32'h12C) begin e.fix = 1; e.fix_pc = 32'h200; end
      exp_q.push_back(e);
      if (e.fix) pc = e.fix_pc;
      else if (e.taken) pc = pc + off_of(pc);
      else pc = pc + 4;
    end
  endtask

  function automatic string tag_of(exp_t e, bit after_fix);
    if (after_fix) return "R7";
    if (e.kind == 1) return e.taken ? "R3" : "R4";
    if (e.kind >= 2) return "R5";
    return "R2";
  endfunction

  // monitor
  int ncyc = 0, last_hs = 0;
  bit last_taken = 0, last_fix = 0, have_last = 0;
  bit prev_stall = 0, prev_fix = 0, prev_req_wait = 0;
  logic [31:0] prev_pc, prev_instr, prev_addr;

  always @(negedge clk) begin
    if (started && !finished) begin
      ncyc++;
      if (prev_stall && !prev_fix) begin
        check(dec_valid && dec_pc == prev_pc && dec_instr == prev_instr,
              "R8", "held instruction", dec_pc, prev_pc);
      end
      if (prev_req_wait)
        check(imem_req_addr == prev_addr, "R9", "ungranted request address", imem_req_addr, prev_addr);
      if (dec_valid && dec_ready) begin
        exp_t e;
        e = exp_q.pop_front();
        check(dec_pc == e.pc, tag_of(e, last_fix), "pc", dec_pc, e.pc);
        check(dec_instr == e.instr, tag_of(e, last_fix), "instr", dec_instr, e.instr);
        check(dec_pred_taken == e.taken, tag_of(e, last_fix), "taken flag",
              32'(dec_pred_taken), 32'(e.taken));
        if (have_last && !phase2 && last_fix)
          check(ncyc - last_hs == 4, "R7", "fix latency", ncyc - last_hs, 4);
        else if (have_last && !phase2 && last_taken)
          check(ncyc - last_hs == 2, "R6", "taken gap", ncyc - last_hs, 2);
        have_last = 1; last_hs = ncyc; last_taken = e.taken; last_fix = e.fix;
        if (e.fix) begin pend_fix = 1; pend_pc = e.fix_pc; end
        if (e.pc == 32'h200) phase2 = 1;
        if (exp_q.size() == 0) begin
          finished = 1;
          $display("CHECKS %0d ERRORS %0d", checks, errors);
          $finish;
        end
      end
      prev_stall = dec_valid && !dec_ready;
      prev_fix   = ex_fix_valid;
      prev_pc    = dec_pc;
      prev_instr = dec_instr;
      prev_req_wait = imem_req_valid && !imem_req_ready && !imem_rsp_valid && !ex_fix_valid;
      prev_addr  = imem_req_addr;
    end
  end

  initial begin
    rst_n = 1'b0; dec_ready = 1'b0; imem_req_ready = 1'b1;
    ex_fix_valid = 1'b0; ex_fix_pc = '0;
    build_trace();
    repeat (3) @(negedge clk);
    check(dec_valid == 1'b0, "R1", "valid in reset", 32'(dec_valid), 0);
    check(imem_req_addr == BOOT, "R1", "boot address", imem_req_addr, BOOT);
    @(posedge clk); #1;
    rst_n = 1'b1; dec_ready = 1'b1; started = 1;
    for (int k = 0; k < 5000; k++) begin
      @(posedge clk); #1;
      if (pend_fix) begin
        ex_fix_valid = 1'b1; ex_fix_pc = pend_pc; dec_ready = 1'b0; pend_fix = 0;
      end else begin
        ex_fix_valid = 1'b0;
        if (phase2) begin
          dec_ready = (k % 3) != 0;
          imem_req_ready = (k % 4) != 1;
        end else begin
          dec_ready = 1'b1;
          imem_req_ready = 1'b1;
        end
      end
    end
    finished = 1;
    errors++; checks++;
    $display("FAIL watchdog expired, remaining=%0d expected=0", exp_q.size());
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule